// File: doc/BRIEF.md
# Configurable Radio Packet Assembler

The assembler turns a host payload into a complete over-the-air packet, delivered as a serial bit stream. The framing fields come from configuration inputs that are set once and change rarely: an alternating training pattern of programmable byte count, a sync word of one to four bytes, an optional header of up to four bytes, an optional length byte and an optional 16-bit checksum. The host supplies only the payload bytes, through a valid/ready byte interface.

A one-cycle start pulse begins a packet. The block emits one bit in each cycle that `bit_vld_o` is high, most significant bit of each byte first. `bit_vld_o` drops only while the block waits for a payload byte the host has not yet offered. One cycle after the final bit, `done_o` pulses. The configuration inputs must be held stable from the start pulse until `done_o`.

Top module: `pkt_assembler`

## Requirements
- R1: The packet opens with N bytes of 0x55 sent MSB first, so the stream starts with a 0 and alternates. N is `cfg_pre_len_i`, and a value of 0 is treated as 1.
- R2: The sync field follows the preamble. A `cfg_sync_len_i` value of k sends k+1 bytes, taken from the top byte of `cfg_sync_word_i` (bits 31:24) downward.
- R3: The header field follows the sync word. `cfg_hdr_len_i` gives its byte count from 0 to 4, and values above 4 act as 4. The bytes are taken from the top byte of `cfg_hdr_i` downward. A count of 0 omits the field.
- R4: When `cfg_len_en_i` is 1, one byte equal to `cfg_pay_len_i` follows the header. When it is 0, no length byte is sent.
- R5: Exactly `cfg_pay_len_i` payload bytes (0 to 255) are accepted and sent in order. A byte is accepted in a cycle where `pl_valid_i` and `pl_ready_o` are both 1.
- R6: When `cfg_crc_en_i` is 1, two checksum bytes close the packet, high byte first. The checksum uses polynomial 0x1021 with initial value 0xFFFF, processes data MSB first with no reflection and no final XOR, and covers the header, length and payload bytes only.
- R7: Every byte is serialized MSB first, one bit per cycle with `bit_vld_o` high. No gaps occur except while a payload byte is awaited.
- R8: `done_o` is high for exactly one cycle, the cycle right after the last bit, and `bit_vld_o` is low in that cycle.
- R9: A start pulse that arrives while a packet is in progress is ignored, and the packet in flight is unchanged.
- R10: After reset, `bit_vld_o`, `done_o` and `pl_ready_o` are 0.
- R11: Between packets, `bit_vld_o` and `pl_ready_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a packet (single-cycle pulse) |
| cfg_pre_len_i | input | 8 | Preamble byte count |
| cfg_sync_len_i | input | 2 | Sync byte count minus one |
| cfg_sync_word_i | input | 32 | Sync word, first byte in bits 31:24 |
| cfg_hdr_len_i | input | 3 | Header byte count (0 to 4) |
| cfg_hdr_i | input | 32 | Header bytes, first byte in bits 31:24 |
| cfg_len_en_i | input | 1 | Insert the length byte |
| cfg_pay_len_i | input | 8 | Payload byte count |
| cfg_crc_en_i | input | 1 | Append the 16-bit checksum |
| pl_data_i | input | 8 | Payload byte |
| pl_valid_i | input | 1 | Payload byte offered |
| pl_ready_o | output | 1 | Assembler takes the offered byte this cycle |
| bit_o | output | 1 | Serial output bit |
| bit_vld_o | output | 1 | `bit_o` is valid this cycle |
| done_o | output | 1 | Packet finished (one cycle) |

## Verification
If the field sequencer skips, repeats or stalls a field, the collected stream is misaligned from the first affected byte onward. The per-field comparison then names the field within eight bit times of the fault. A checksum register that misses an update or is not cleared only shows up in the final 16 bits, so every packet with the checksum enabled compares those bits, and one fixed vector pins down the polynomial and initial value. A serializer count that is off by one changes the total bit count, which surfaces at `done_o` as a wrong length or a missing pulse.

// File: rtl/pkt_asm_pkg.sv
package pkt_asm_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] TRAIN_BYTE = 8'h55;
  localparam logic [15:0]       CHK_POLY   = 16'h1021;
  localparam logic [15:0]       CHK_INIT   = 16'hFFFF;

  typedef enum logic [3:0] {
    FLD_IDLE,
    FLD_PRE,
    FLD_SYNC,
    FLD_HDR,
    FLD_LEN,
    FLD_PAY,
    FLD_CHKH,
    FLD_CHKL,
    FLD_FIN
  } field_e;

  // one byte through the checksum, MSB first
  function automatic logic [15:0] chk_step(input logic [15:0] cur,
                                           input logic [BYTE_W-1:0] data);
    logic [15:0] c;
    c = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (c[15] ^ data[i]) c = {c[14:0], 1'b0} ^ CHK_POLY;
      else                 c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/pkt_serializer.sv
module pkt_serializer
  import pkt_asm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              bit_o,
  output logic              vld_o,
  output logic              room_o,
  output logic              last_o
);

  logic [BYTE_W-1:0]    sh_q, sh_d;
  logic [BIT_IDX_W-1:0] cnt_q, cnt_d;
  logic                 full_q, full_d;

  assign last_o = full_q && (cnt_q == BIT_IDX_W'(BYTE_W - 1));
  assign room_o = !full_q || last_o;
  assign bit_o  = sh_q[BYTE_W-1];
  assign vld_o  = full_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    if (take_i) begin
      sh_d   = byte_i;
      cnt_d  = '0;
      full_d = 1'b1;
    end else if (full_q) begin
      sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
      cnt_d  = cnt_q + 1'b1;
      full_d = !last_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/pkt_chk16.sv
module pkt_chk16
  import pkt_asm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [15:0]       chk_o
);

  logic [15:0] chk_q, chk_d;

  always_comb begin
    chk_d = chk_q;
    if (clr_i)      chk_d = CHK_INIT;
    else if (upd_i) chk_d = chk_step(chk_q, byte_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_q <= CHK_INIT;
    else        chk_q <= chk_d;
  end

  assign chk_o = chk_q;

endmodule

// File: rtl/pkt_field_seq.sv
module pkt_field_seq
  import pkt_asm_pkg::*;
#(
  parameter  int SYNC_MAX = 4,
  parameter  int HDR_MAX  = 4,
  localparam int SL_W     = $clog2(SYNC_MAX),
  localparam int HL_W     = $clog2(HDR_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      cfg_pre_len_i,
  input  logic [SL_W-1:0]       cfg_sync_len_i,
  input  logic [8*SYNC_MAX-1:0] cfg_sync_word_i,
  input  logic [HL_W-1:0]       cfg_hdr_len_i,
  input  logic [8*HDR_MAX-1:0]  cfg_hdr_i,
  input  logic                  cfg_len_en_i,
  input  logic [CNT_W-1:0]      cfg_pay_len_i,
  input  logic                  cfg_crc_en_i,
  input  logic [BYTE_W-1:0]     pl_data_i,
  input  logic                  pl_valid_i,
  input  logic                  room_i,
  input  logic                  last_bit_i,
  input  logic [15:0]           chk_i,
  output logic                  take_o,
  output logic [BYTE_W-1:0]     byte_o,
  output logic                  pl_ready_o,
  output logic                  chk_clr_o,
  output logic                  chk_upd_o,
  output logic                  done_o,
  output logic                  busy_o
);

  field_e          fld_q, fld_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  logic [CNT_W-1:0] pre_n, sync_n, hdr_n;
  field_e           after_pay, after_len, after_hdr, after_sync, succ;
  logic             avail, fld_last;
  logic [BYTE_W-1:0] sync_byte, hdr_byte;

  // effective field lengths
  assign pre_n  = (cfg_pre_len_i == '0) ? CNT_W'(1) : cfg_pre_len_i;
  assign sync_n = CNT_W'(cfg_sync_len_i) + CNT_W'(1);
  assign hdr_n  = (cfg_hdr_len_i > HL_W'(HDR_MAX)) ? CNT_W'(HDR_MAX)
                                                   : CNT_W'(cfg_hdr_len_i);

  // successor of each optional field, skipping empty ones
  assign after_pay  = cfg_crc_en_i ? FLD_CHKH : FLD_FIN;
  assign after_len  = (cfg_pay_len_i != '0) ? FLD_PAY : after_pay;
  assign after_hdr  = cfg_len_en_i ? FLD_LEN : after_len;
  assign after_sync = (hdr_n != '0) ? FLD_HDR : after_hdr;

  // byte pick from the register-held words, first byte on top
  always_comb begin
    sync_byte = '0;
    for (int k = 0; k < SYNC_MAX; k++)
      if (idx_q == CNT_W'(k)) sync_byte = cfg_sync_word_i[8*(SYNC_MAX-1-k) +: 8];
  end

  always_comb begin
    hdr_byte = '0;
    for (int k = 0; k < HDR_MAX; k++)
      if (idx_q == CNT_W'(k)) hdr_byte = cfg_hdr_i[8*(HDR_MAX-1-k) +: 8];
  end

  // byte source for the current field
  always_comb begin
    avail    = 1'b0;
    byte_o   = '0;
    fld_last = 1'b0;
    succ     = FLD_FIN;
    unique case (fld_q)
      FLD_PRE: begin
        avail    = 1'b1;
        byte_o   = TRAIN_BYTE;
        fld_last = (idx_q == pre_n - CNT_W'(1));
        succ     = FLD_SYNC;
      end
      FLD_SYNC: begin
        avail    = 1'b1;
        byte_o   = sync_byte;
        fld_last = (idx_q == sync_n - CNT_W'(1));
        succ     = after_sync;
      end
      FLD_HDR: begin
        avail    = 1'b1;
        byte_o   = hdr_byte;
        fld_last = (idx_q == hdr_n - CNT_W'(1));
        succ     = after_hdr;
      end
      FLD_LEN: begin
        avail    = 1'b1;
        byte_o   = cfg_pay_len_i;
        fld_last = 1'b1;
        succ     = after_len;
      end
      FLD_PAY: begin
        avail    = pl_valid_i;
        byte_o   = pl_data_i;
        fld_last = (idx_q == cfg_pay_len_i - CNT_W'(1));
        succ     = after_pay;
      end
      FLD_CHKH: begin
        avail    = 1'b1;
        byte_o   = chk_i[15:8];
        fld_last = 1'b1;
        succ     = FLD_CHKL;
      end
      FLD_CHKL: begin
        avail    = 1'b1;
        byte_o   = chk_i[7:0];
        fld_last = 1'b1;
        succ     = FLD_FIN;
      end
      default: ;
    endcase
  end

  assign take_o     = avail && room_i;
  assign pl_ready_o = (fld_q == FLD_PAY) && room_i;
  assign chk_clr_o  = start_i && (fld_q == FLD_IDLE);
  assign chk_upd_o  = take_o && ((fld_q == FLD_HDR) || (fld_q == FLD_LEN) ||
                                 (fld_q == FLD_PAY));

  // next state
  always_comb begin
    fld_d  = fld_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (fld_q == FLD_IDLE) begin
      if (start_i) begin
        fld_d = FLD_PRE;
        idx_d = '0;
      end
    end else if (fld_q == FLD_FIN) begin
      if (last_bit_i) begin
        fld_d  = FLD_IDLE;
        done_d = 1'b1;
      end
    end else if (take_o) begin
      if (fld_last) begin
        fld_d = succ;
        idx_d = '0;
      end else begin
        idx_d = idx_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= FLD_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      fld_q  <= fld_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign busy_o = (fld_q != FLD_IDLE);

endmodule

// File: rtl/pkt_assembler.sv
module pkt_assembler
  import pkt_asm_pkg::*;
#(
  parameter  int SYNC_MAX = 4,
  parameter  int HDR_MAX  = 4,
  localparam int SL_W     = $clog2(SYNC_MAX),
  localparam int HL_W     = $clog2(HDR_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      cfg_pre_len_i,
  input  logic [SL_W-1:0]       cfg_sync_len_i,
  input  logic [8*SYNC_MAX-1:0] cfg_sync_word_i,
  input  logic [HL_W-1:0]       cfg_hdr_len_i,
  input  logic [8*HDR_MAX-1:0]  cfg_hdr_i,
  input  logic                  cfg_len_en_i,
  input  logic [CNT_W-1:0]      cfg_pay_len_i,
  input  logic                  cfg_crc_en_i,
  input  logic [BYTE_W-1:0]     pl_data_i,
  input  logic                  pl_valid_i,
  output logic                  pl_ready_o,
  output logic                  bit_o,
  output logic                  bit_vld_o,
  output logic                  done_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic              take, room, last_bit, chk_clr, chk_upd, busy;
  logic [BYTE_W-1:0] byte_nx;
  logic [15:0]       chk;

  pkt_field_seq #(
    .SYNC_MAX (SYNC_MAX),
    .HDR_MAX  (HDR_MAX)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .start_i         (start_i),
    .cfg_pre_len_i   (cfg_pre_len_i),
    .cfg_sync_len_i  (cfg_sync_len_i),
    .cfg_sync_word_i (cfg_sync_word_i),
    .cfg_hdr_len_i   (cfg_hdr_len_i),
    .cfg_hdr_i       (cfg_hdr_i),
    .cfg_len_en_i    (cfg_len_en_i),
    .cfg_pay_len_i   (cfg_pay_len_i),
    .cfg_crc_en_i    (cfg_crc_en_i),
    .pl_data_i       (pl_data_i),
    .pl_valid_i      (pl_valid_i),
    .room_i          (room),
    .last_bit_i      (last_bit),
    .chk_i           (chk),
    .take_o          (take),
    .byte_o          (byte_nx),
    .pl_ready_o      (pl_ready_o),
    .chk_clr_o       (chk_clr),
    .chk_upd_o       (chk_upd),
    .done_o          (done_o),
    .busy_o          (busy)
  );

  pkt_chk16 u_chk16 (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_i  (chk_clr),
    .upd_i  (chk_upd),
    .byte_i (byte_nx),
    .chk_o  (chk)
  );

  pkt_serializer u_ser (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .take_i (take),
    .byte_i (byte_nx),
    .bit_o  (bit_o),
    .vld_o  (bit_vld_o),
    .room_o (room),
    .last_o (last_bit)
  );

endmodule

// File: rtl/pkt_asm_chk.sv
module pkt_asm_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld_i,
  input logic done_i,
  input logic pl_ready_i,
  input logic busy_i
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !done_i);

  // R8
  done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> $past(bit_vld_i));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (!bit_vld_i && !busy_i));

  // R8
  end_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |-> done_i);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (!bit_vld_i && !pl_ready_i));

endmodule

bind pkt_assembler pkt_asm_chk u_asm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_vld_i  (bit_vld_o),
  .done_i     (done_o),
  .pl_ready_i (pl_ready_o),
  .busy_i     (busy)
);

// File: tb/pkt_assembler_test.sv
module pkt_assembler_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  cfg_pre_len_i = 8'd1;
  logic [1:0]  cfg_sync_len_i = '0;
  logic [31:0] cfg_sync_word_i = '0;
  logic [2:0]  cfg_hdr_len_i = '0;
  logic [31:0] cfg_hdr_i = '0;
  logic        cfg_len_en_i = 1'b0;
  logic [7:0]  cfg_pay_len_i = '0;
  logic        cfg_crc_en_i = 1'b0;
  logic [7:0]  pl_data_i = '0;
  logic        pl_valid_i = 1'b0;
  logic        pl_ready_o, bit_o, bit_vld_o, done_o;

  always #5 clk = ~clk;

  pkt_assembler uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .cfg_pre_len_i (cfg_pre_len_i), .cfg_sync_len_i (cfg_sync_len_i),
    .cfg_sync_word_i (cfg_sync_word_i), .cfg_hdr_len_i (cfg_hdr_len_i),
    .cfg_hdr_i (cfg_hdr_i), .cfg_len_en_i (cfg_len_en_i),
    .cfg_pay_len_i (cfg_pay_len_i), .cfg_crc_en_i (cfg_crc_en_i),
    .pl_data_i (pl_data_i), .pl_valid_i (pl_valid_i),
    .pl_ready_o (pl_ready_o), .bit_o (bit_o), .bit_vld_o (bit_vld_o),
    .done_o (done_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] pay [256];
  bit exp_q[$];
  bit rx_q[$];
  int seg_off[6];
  int seg_len[6];
  string seg_req[6] = '{"R1 preamble", "R2 R7 sync", "R3 header",
                        "R4 length", "R5 payload", "R6 checksum"};

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(input logic [15:0] c,
                                           input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
  endtask

  task automatic build_expected();
    int np, ns, nh;
    logic [15:0] c;
    exp_q.delete();
    c  = 16'hFFFF;
    np = (cfg_pre_len_i == 0) ? 1 : int'(cfg_pre_len_i);
    ns = int'(cfg_sync_len_i) + 1;
    nh = (cfg_hdr_len_i > 3'd4) ? 4 : int'(cfg_hdr_len_i);
    seg_off[0] = 0;
    for (int i = 0; i < np; i++) push_byte(8'h55);
    seg_off[1] = exp_q.size();
    for (int i = 0; i < ns; i++) push_byte(cfg_sync_word_i[31-8*i -: 8]);
    seg_off[2] = exp_q.size();
    for (int i = 0; i < nh; i++) begin
      push_byte(cfg_hdr_i[31-8*i -: 8]);
      c = ref_step(c, cfg_hdr_i[31-8*i -: 8]);
    end
    seg_off[3] = exp_q.size();
    if (cfg_len_en_i) begin
      push_byte(cfg_pay_len_i);
      c = ref_step(c, cfg_pay_len_i);
    end
    seg_off[4] = exp_q.size();
    for (int i = 0; i < int'(cfg_pay_len_i); i++) begin
      push_byte(pay[i]);
      c = ref_step(c, pay[i]);
    end
    seg_off[5] = exp_q.size();
    if (cfg_crc_en_i) push_byte(c[15:8]);
    if (cfg_crc_en_i) push_byte(c[7:0]);
    for (int s = 0; s < 5; s++) seg_len[s] = seg_off[s+1] - seg_off[s];
    seg_len[5] = exp_q.size() - seg_off[5];
  endtask

  // runs one packet; stall_pct = chance of withholding a payload byte
  task automatic run_pkt(input int stall_pct, input bit poke);
    int  pidx = 0;
    int  cyc = 0;
    bit  got_done = 0;
    bit  prev_vld = 0;
    bit  poked = 0;
    bit  done_ok = 0;
    build_expected();
    rx_q.delete();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!got_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (done_o) begin
        got_done = 1;
        done_ok  = prev_vld && !bit_vld_o && (rx_q.size() == exp_q.size());
      end
      prev_vld = bit_vld_o;
      if (bit_vld_o) rx_q.push_back(bit_o);
      // R9: start pulse while the packet is in progress
      if (poke && !poked && rx_q.size() == 12) begin
        start_i = 1'b1;
        poked = 1;
      end
      if (pidx < int'(cfg_pay_len_i) && ($urandom % 100) >= stall_pct) begin
        pl_valid_i = 1'b1;
        pl_data_i  = pay[pidx];
      end else begin
        pl_valid_i = 1'b0;
        pl_data_i  = 8'hxx === 8'hxx ? 8'h00 : 8'h00;
      end
      if (pl_ready_o && pl_valid_i) pidx++;
    end
    pl_valid_i = 1'b0;
    check(got_done, "R8 done seen", got_done, 1);
    check(done_ok, "R8 done timing", rx_q.size(), exp_q.size());
    check(pidx == int'(cfg_pay_len_i), "R5 bytes accepted", pidx, cfg_pay_len_i);
    for (int s = 0; s < 6; s++) begin
      int bad = -1;
      for (int i = 0; i < seg_len[s]; i++)
        if (bad < 0 && (seg_off[s] + i >= rx_q.size() ||
                        rx_q[seg_off[s]+i] != exp_q[seg_off[s]+i]))
          bad = i;
      if (bad >= 0)
        check(0, poke ? {seg_req[s], " R9"} : seg_req[s],
              (seg_off[s]+bad < rx_q.size()) ? rx_q[seg_off[s]+bad] : 2,
              exp_q[seg_off[s]+bad]);
      else
        check(1, seg_req[s], 0, 0);
    end
    // R11: quiet between packets
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!bit_vld_o && !pl_ready_o && !done_o, "R11 idle quiet",
            {bit_vld_o, pl_ready_o, done_o}, 0);
    end
  endtask

  task automatic rand_cfg();
    cfg_pre_len_i   = 8'($urandom % 6);
    cfg_sync_len_i  = 2'($urandom % 4);
    cfg_sync_word_i = $urandom;
    cfg_hdr_len_i   = 3'($urandom % 8);
    cfg_hdr_i       = $urandom;
    cfg_len_en_i    = 1'($urandom % 2);
    cfg_pay_len_i   = 8'($urandom % 21);
    cfg_crc_en_i    = 1'($urandom % 2);
    for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10
    check(!bit_vld_o && !done_o && !pl_ready_o, "R10 reset state",
          {bit_vld_o, done_o, pl_ready_o}, 0);

    // minimal packet: 1 preamble (0 -> 1), 1 sync byte, nothing else
    cfg_pre_len_i = 8'd0; cfg_sync_len_i = 2'd0; cfg_sync_word_i = 32'hA7000000;
    cfg_hdr_len_i = 3'd0; cfg_len_en_i = 1'b0; cfg_pay_len_i = 8'd0;
    cfg_crc_en_i = 1'b0;
    run_pkt(0, 0);
    check(rx_q.size() == 16, "R1 R2 minimal length", rx_q.size(), 16);
    check(rx_q.size() > 1 && rx_q[0] == 1'b0 && rx_q[1] == 1'b1,
          "R1 first bits 0 then 1", rx_q.size() > 1 ? {rx_q[0], rx_q[1]} : 0, 1);

    // known checksum vector over "123456789"
    cfg_pre_len_i = 8'd2; cfg_sync_len_i = 2'd1; cfg_sync_word_i = 32'h2DD40000;
    cfg_hdr_len_i = 3'd0; cfg_len_en_i = 1'b0; cfg_pay_len_i = 8'd9;
    cfg_crc_en_i = 1'b1;
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    run_pkt(30, 0);
    begin
      logic [15:0] tail = '0;
      for (int i = 0; i < 16; i++)
        if (rx_q.size() >= 16) tail = {tail[14:0], rx_q[rx_q.size()-16+i]};
      check(tail == 16'h29B1, "R6 known vector", tail, 16'h29B1);
    end

    // header count above 4 acts as 4, length byte on, heavy stalls
    cfg_pre_len_i = 8'd3; cfg_sync_len_i = 2'd3; cfg_sync_word_i = 32'h12345678;
    cfg_hdr_len_i = 3'd7; cfg_hdr_i = 32'hCAFEF00D; cfg_len_en_i = 1'b1;
    cfg_pay_len_i = 8'd5; cfg_crc_en_i = 1'b1;
    for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
    run_pkt(70, 0);
    check(seg_len[2] == 32, "R3 header clamp", seg_len[2], 32);

    // start pulse mid-packet
    rand_cfg();
    cfg_pay_len_i = 8'd6;
    run_pkt(20, 1);

    // long preamble and full payload
    cfg_pre_len_i = 8'd255; cfg_sync_len_i = 2'd2; cfg_hdr_len_i = 3'd4;
    cfg_len_en_i = 1'b1; cfg_pay_len_i = 8'd255; cfg_crc_en_i = 1'b1;
    run_pkt(10, 0);

    // constrained random packets
    for (int n = 0; n < 24; n++) begin
      rand_cfg();
      run_pkt(int'($urandom % 60), n % 5 == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule